// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps the time of day in four packed-BCD registers: hundredths of a second, seconds, minutes and hours. An external tick advances the hundredths register, and each register passes a carry to the next one when it wraps. The hours register runs either as a 24-hour count or as a 12-hour count with an AM/PM flag. A control bit stored inside the hours byte selects the mode. When the hours register completes a full day, the block emits a one-cycle day-carry pulse for a calendar block that sits outside it.

Software loads any register through a write port. Each byte is ANDed with that register's writable-bit mask before it is stored, and any register can be read back through a combinational read port. A halt bit in the seconds register freezes the whole chain. Wrap detection uses an exact match against each register's final count, and each increment is a per-nibble BCD add. Because of this, values outside the legal range keep counting in a fixed, predictable way.

Top module: `bcd_tod_chain`

## Requirements
- R1: Register select codes are 0 = hundredths, 1 = seconds, 2 = minutes, 3 = hours. `rd_data_o` shows the stored byte of the register chosen by `rd_sel_i` in the same cycle. After reset, every register reads 00h and `day_carry_o` is low.
- R2: Each `tick_i` cycle without halt advances hundredths through 00h..99h. A tick while it holds 99h returns it to 00h and increments seconds.
- R3: The seconds count field is bits 6:0, and minutes uses bits 6:0. Each runs 00h..59h. When a register advances while its field holds 59h, the field returns to 00h and the next register is incremented.
- R4: Hours bit 6 selects the mode: 0 is 24-hour, 1 is 12-hour. In 24-hour mode hours counts 00h..23h, and an advance at 23h gives 00h with a day carry.
- R5: In 12-hour mode, the AM hours run 52h, 41h..49h, 50h, 51h. An advance at 51h gives 72h, which sets the PM flag (bit 5), and there is no day carry.
- R6: In 12-hour mode, the PM hours run 72h, 61h..69h, 70h, 71h. An advance at 71h gives 52h, clears PM and produces a day carry.
- R7: A write stores `wr_data_i` ANDed with the register's mask. The masks are FFh for hundredths, FFh for seconds, 7Fh for minutes and 7Fh for hours.
- R8: A register wraps only when its count field equals the final count exactly. Any other value advances by a BCD step. A low nibble of 9 or more becomes 0 and adds one to the high nibble, which wraps modulo 16. The result is then cut to the count field. In hours, this step applies to every value except the four 12-hour special codes and the 24-hour code 23h.
- R9: While seconds bit 7 (halt) is set, no register advances or wraps, and no day carry is produced. Writes still take effect.
- R10: A write to a register in the same cycle as an advance into that register takes priority. The written value is stored, and that register passes no carry onward in that cycle.
- R11: `day_carry_o` is high for exactly one cycle: the first cycle in which the hours register shows its wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Hundredths advance strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | 8 | Write data, before masking |
| rd_sel_i | input | 2 | Register selected for the read |
| rd_data_o | output | 8 | Stored byte of the selected register |
| day_carry_o | output | 1 | One-cycle pulse when the hours register wraps to a new day |

## Verification
A write or a tick applied before a rising edge shows in the registers right after that edge, and the day-carry pulse, which is registered, shows in the same cycle. The bench drives stimulus for one cycle at a falling edge. A software model steps at the rising edge, and all four registers and the pulse are compared at the next falling edge, with `rd_sel_i` walked through each code, since the read path adds no delay. The sweeps cover every byte in every register: each byte is written, and then one tick is applied with all lower registers at their final counts. The sweeps also cover full 12-hour and 24-hour days, a long free run, writes colliding with ticks, and halt.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NIB_W     = REG_W / 2;
  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned MODE_BIT  = 6;
  localparam int unsigned PM_BIT    = 5;
  localparam int unsigned HALT_BIT  = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_HUND = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_MIN  = 2'd2,
    SEL_HOUR = 2'd3
  } reg_sel_e;

  // per-nibble BCD step; high nibble wraps modulo 16
  function automatic logic [REG_W-1:0] bcd_step(input logic [REG_W-1:0] v);
    logic [NIB_W-1:0] lo, hi;
    lo = v[NIB_W-1:0];
    hi = v[REG_W-1:NIB_W];
    if (lo >= NIB_W'(9)) bcd_step = {hi + NIB_W'(1), NIB_W'(0)};
    else                 bcd_step = {hi, lo + NIB_W'(1)};
  endfunction

  function automatic logic [REG_W-1:0] lane_max(input int unsigned idx);
    lane_max = (idx == 0) ? 8'h99 : 8'h59;
  endfunction

  function automatic logic [REG_W-1:0] lane_cnt_mask(input int unsigned idx);
    lane_cnt_mask = (idx == 0) ? 8'hFF : 8'h7F;
  endfunction

  function automatic logic [REG_W-1:0] lane_wr_mask(input int unsigned idx);
    lane_wr_mask = (idx == 2) ? 8'h7F : 8'hFF;
  endfunction

  localparam logic [REG_W-1:0] HOUR_WR_MASK = 8'h7F;
  localparam logic [REG_W-1:0] H24_LAST     = 8'h23;
  localparam logic [REG_W-1:0] H24_FIRST    = 8'h00;
  localparam logic [REG_W-1:0] H12_AM_TWELVE = 8'h52;
  localparam logic [REG_W-1:0] H12_AM_ONE    = 8'h41;
  localparam logic [REG_W-1:0] H12_AM_LAST   = 8'h51;
  localparam logic [REG_W-1:0] H12_PM_TWELVE = 8'h72;
  localparam logic [REG_W-1:0] H12_PM_ONE    = 8'h61;
  localparam logic [REG_W-1:0] H12_PM_LAST   = 8'h71;
endpackage

// File: rtl/bcd_lane_ctr.sv
module bcd_lane_ctr
  import bcd_tod_pkg::*;
#(
  parameter logic [REG_W-1:0] MAX_VAL  = 8'h99,
  parameter logic [REG_W-1:0] CNT_MASK = 8'hFF,
  parameter logic [REG_W-1:0] WR_MASK  = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] val_o,
  output logic             carry_o
);
  logic [REG_W-1:0] val_q, val_d;
  logic             at_max, advance;

  assign at_max  = ((val_q & CNT_MASK) == MAX_VAL);
  assign advance = inc_i & ~wr_en_i;
  assign carry_o = advance & at_max;
  assign val_o   = val_q;

  always_comb begin
    val_d = val_q;
    if (wr_en_i) begin
      val_d = wr_data_i & WR_MASK;
    end else if (inc_i) begin
      val_d = (val_q & ~CNT_MASK) |
              (at_max ? '0 : (bcd_step(val_q) & CNT_MASK));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  AST_LANE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> val_q == $past(wr_data_i & WR_MASK)); // R7

  AST_LANE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_en_i && (val_q & CNT_MASK) == MAX_VAL) |=> (val_q & CNT_MASK) == '0); // R8

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_en_i) |=> $stable(val_q)); // R9
endmodule

// File: rtl/bcd_hour_ctr.sv
module bcd_hour_ctr
  import bcd_tod_pkg::*;
#(
  parameter logic [REG_W-1:0] WR_MASK = HOUR_WR_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] val_o,
  output logic             roll_o
);
  logic [REG_W-1:0] val_q, val_d, step_val;
  logic             day_match, mode_12h, advance;

  assign mode_12h = val_q[MODE_BIT];
  assign advance  = inc_i & ~wr_en_i;
  assign roll_o   = advance & day_match;
  assign val_o    = val_q;

  always_comb begin
    day_match = 1'b0;
    step_val  = bcd_step(val_q) & WR_MASK;
    if (mode_12h) begin
      unique case (val_q)
        H12_AM_TWELVE: step_val = H12_AM_ONE;
        H12_PM_TWELVE: step_val = H12_PM_ONE;
        H12_AM_LAST:   step_val = H12_PM_TWELVE;
        H12_PM_LAST: begin
          step_val  = H12_AM_TWELVE;
          day_match = 1'b1;
        end
        default: ;
      endcase
    end else if (val_q == H24_LAST) begin
      step_val  = H24_FIRST;
      day_match = 1'b1;
    end
  end

  always_comb begin
    val_d = val_q;
    if (wr_en_i)    val_d = wr_data_i & WR_MASK;
    else if (inc_i) val_d = step_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  AST_HR_24_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_en_i && val_q == H24_LAST) |=> val_q == H24_FIRST); // R4

  AST_HR_AM_TO_PM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_en_i && val_q == H12_AM_LAST) |=> (val_q == H12_PM_TWELVE && val_q[PM_BIT])); // R5

  AST_HR_PM_TO_AM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_en_i && val_q == H12_PM_LAST) |=> (val_q == H12_AM_TWELVE && !val_q[PM_BIT])); // R6

  AST_HR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> val_q == $past(wr_data_i & WR_MASK)); // R7
endmodule

// File: rtl/bcd_tod_chain.sv
module bcd_tod_chain
  import bcd_tod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             day_carry_o
);
  logic [REG_W-1:0] lane_val [NUM_LANES];
  logic [NUM_LANES:0] inc;
  logic [NUM_LANES-1:0] lane_wr;
  logic [REG_W-1:0] hour_val;
  logic             hour_wr, hour_roll, halt, day_q;

  assign halt   = lane_val[SEL_SEC][HALT_BIT];
  assign inc[0] = tick_i & ~halt;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_wr[i] = wr_en_i && (wr_sel_i == SEL_W'(i));
    bcd_lane_ctr #(
      .MAX_VAL (lane_max(i)),
      .CNT_MASK(lane_cnt_mask(i)),
      .WR_MASK (lane_wr_mask(i))
    ) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[i]),
      .wr_en_i  (lane_wr[i]),
      .wr_data_i(wr_data_i),
      .val_o    (lane_val[i]),
      .carry_o  (inc[i+1])
    );
  end

  assign hour_wr = wr_en_i && (wr_sel_i == SEL_HOUR);

  bcd_hour_ctr u_hour (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc[NUM_LANES]),
    .wr_en_i  (hour_wr),
    .wr_data_i(wr_data_i),
    .val_o    (hour_val),
    .roll_o   (hour_roll)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) day_q <= 1'b0;
    else         day_q <= hour_roll;
  end
  assign day_carry_o = day_q;

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_HUND: rd_data_o = lane_val[0];
      SEL_SEC:  rd_data_o = lane_val[1];
      SEL_MIN:  rd_data_o = lane_val[2];
      default:  rd_data_o = hour_val;
    endcase
  end

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !wr_en_i) |=> ($stable(lane_val[0]) && $stable(hour_val) && !day_carry_o)); // R9

  AST_DAY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> !day_carry_o); // R11

  AST_NO_CARRY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_HUND) |=> $stable(lane_val[1])); // R10
endmodule

// File: tb/tb_bcd_tod_chain.sv
module tb_bcd_tod_chain;
  localparam time CYC = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       day_carry;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] m [4];
  logic       mday;

  always #(CYC/2) clk = ~clk;

  bcd_tod_chain dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .day_carry_o(day_carry)
  );

  function automatic logic [7:0] ninc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] wmask(input int s);
    return (s >= 2) ? 8'h7F : 8'hFF;
  endfunction

  // reference model from the requirements
  task automatic model_step(input bit t, input bit w, input int s, input logic [7:0] d);
    logic [7:0] n [4];
    bit c0, c1, c2, roll;
    n = m; c0 = 0; c1 = 0; c2 = 0; roll = 0;
    if (t && !m[1][7] && !(w && s == 0)) begin
      if (m[0] == 8'h99) begin n[0] = 8'h00; c0 = 1; end
      else n[0] = ninc(m[0]);
    end
    if (c0 && !(w && s == 1)) begin
      if ((m[1] & 8'h7F) == 8'h59) begin n[1] = m[1] & 8'h80; c1 = 1; end
      else n[1] = (m[1] & 8'h80) | (ninc(m[1]) & 8'h7F);
    end
    if (c1 && !(w && s == 2)) begin
      if ((m[2] & 8'h7F) == 8'h59) begin n[2] = m[2] & 8'h80; c2 = 1; end
      else n[2] = (m[2] & 8'h80) | (ninc(m[2]) & 8'h7F);
    end
    if (c2 && !(w && s == 3)) begin
      if (m[3][6]) begin
        case (m[3])
          8'h52: n[3] = 8'h41;
          8'h72: n[3] = 8'h61;
          8'h51: n[3] = 8'h72;
          8'h71: begin n[3] = 8'h52; roll = 1; end
          default: n[3] = ninc(m[3]) & 8'h7F;
        endcase
      end else if (m[3] == 8'h23) begin
        n[3] = 8'h00; roll = 1;
      end else n[3] = ninc(m[3]) & 8'h7F;
    end
    if (w) n[s] = d & wmask(s);
    m = n;
    mday = roll;
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      vectors++;
      if (rd_data !== m[s]) begin
        errors++;
        $display("FAIL %s reg%0d: got %h expected %h", tag, s, rd_data, m[s]);
      end
    end
    vectors++;
    if (day_carry !== mday) begin
      errors++;
      $display("FAIL %s day_carry: got %b expected %b", tag, day_carry, mday);
    end
  endtask

  // one cycle of stimulus, driven at negedge, checked at next negedge
  task automatic cyc(input bit t, input bit w, input int s, input logic [7:0] d, input string tag);
    tick = t; wr_en = w; wr_sel = 2'(s); wr_data = d;
    @(posedge clk);
    model_step(t, w, s, d);
    @(negedge clk);
    tick = 0; wr_en = 0;
    check_all(tag);
  endtask

  task automatic wr(input int s, input logic [7:0] d, input string tag);
    cyc(0, 1, s, d, tag);
  endtask

  function automatic logic [7:0] lane_last(input int j);
    return (j == 0) ? 8'h99 : 8'h59;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CYC * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    mday = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2/R3: free run through minutes from zero
    for (int k = 0; k < 7000; k++) cyc(1, 0, 0, 8'h00, "R2 R3 free run");

    // R7/R8: every byte into every register, then one tick with lower lanes at final count
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 256; d++) begin
        for (int j = 0; j < 4; j++)
          if (j != r) wr(j, (j < r) ? lane_last(j) : 8'h00, "R7 setup");
        wr(r, 8'(d), "R7 mask");
        cyc(1, 0, 0, 8'h00, "R8 step");
        cyc(0, 0, 0, 8'h00, "R11 pulse end");
      end
    end

    // R4: full 24-hour day
    wr(3, 8'h00, "R4 setup");
    for (int h = 0; h < 25; h++) begin
      wr(0, 8'h99, "R4 setup"); wr(1, 8'h59, "R4 setup"); wr(2, 8'h59, "R4 setup");
      cyc(1, 0, 0, 8'h00, "R4 hour advance");
      cyc(0, 0, 0, 8'h00, "R11 pulse end");
    end

    // R5/R6: full 12-hour day starting at 12 AM
    wr(3, 8'h52, "R5 setup");
    for (int h = 0; h < 25; h++) begin
      wr(0, 8'h99, "R5 setup"); wr(1, 8'h59, "R5 setup"); wr(2, 8'h59, "R5 setup");
      cyc(1, 0, 0, 8'h00, "R5 R6 hour advance");
      cyc(0, 0, 0, 8'h00, "R11 pulse end");
    end

    // R10: write collides with tick
    wr(0, 8'h99, "R10 setup"); wr(1, 8'h12, "R10 setup"); wr(2, 8'h30, "R10 setup");
    cyc(1, 1, 0, 8'h47, "R10 hund write wins");
    wr(0, 8'h99, "R10 setup"); wr(1, 8'h59, "R10 setup");
    cyc(1, 1, 1, 8'h20, "R10 sec write blocks carry");
    wr(0, 8'h99, "R10 setup"); wr(1, 8'h59, "R10 setup"); wr(2, 8'h59, "R10 setup");
    wr(3, 8'h23, "R10 setup");
    cyc(1, 1, 3, 8'h05, "R10 hour write blocks day carry");
    cyc(0, 0, 0, 8'h00, "R10 after");

    // R9: halt freezes chain, writes still land
    wr(0, 8'h99, "R9 setup"); wr(2, 8'h59, "R9 setup"); wr(3, 8'h23, "R9 setup");
    wr(1, 8'hD9, "R9 halt set");
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 8'h00, "R9 frozen");
    cyc(1, 1, 2, 8'h44, "R9 write while halted");
    wr(1, 8'h59, "R9 halt clear");
    cyc(1, 0, 0, 8'h00, "R9 resume");

    finish_run();
  end
endmodule